// File: doc/BRIEF.md
# Two-Channel Flexible Address Mapper

This block turns a system physical address into a channel select and a channel-local address for a memory controller with two channels. Software-owned configuration supplies the installed capacity of each channel and a mapping mode. The block itself is a pure translation stage that sits in front of the per-channel command queues. The result can be registered once at the output. Rank and bank decoding are done downstream.

Flexible mode splits the address space into two zones. The lower zone is twice the size of the smaller channel, and there consecutive 64-byte lines alternate between the channels. Above that zone, addresses run linearly through what is left of the larger channel, starting just past its interleaved share. When both channels hold the same capacity, the lower zone covers everything. Asymmetric mode stacks channel A below channel B. Single mode steers every access to the one populated channel. An address beyond the installed memory raises an out-of-range flag and selects no channel.

Top module: `flex_chan_mapper`

## Requirements
- R1: In flexible mode (mapMode=1), an address below twice the smaller capacity selects the channel given by address bit LINE_BITS (0=A, 1=B). The local address is the system address with that bit removed and the upper bits shifted down by one.
- R2: In flexible mode, an in-range address at or above twice the smaller capacity goes to the larger channel. Its local address is the system address minus the smaller capacity in bytes.
- R3: With equal capacities in flexible mode, every in-range address is interleaved as in R1.
- R4: In asymmetric mode (mapMode=2), an address below capacity A maps to channel A with the local address equal to the system address. Any other in-range address maps to channel B at the system address minus capacity A.
- R5: In single mode (mapMode=0), channel A is used when its capacity is nonzero, otherwise channel B. The local address equals the system address, and the range is that channel's capacity alone.
- R6: An address at or above the mode's installed total, or any address when mapMode=3, sets outOfRange=1 with chanValid=0, chanSel=0 and localAddr=0.
- R7: A valid result always has a local address below the selected channel's capacity. Capacities count units of 2^UNIT_BITS bytes.
- R8: With REG_OUT=1, outputs reflect the inputs of the previous clock edge. While rst is high the outputs are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output register |
| rst | input | 1 | Synchronous active-high reset |
| sysAddr | input | ADDR_W | System physical byte address |
| capUnitsA | input | CAP_W | Channel A capacity in units |
| capUnitsB | input | CAP_W | Channel B capacity in units |
| mapMode | input | 2 | 0 single, 1 flexible, 2 asymmetric, 3 reserved |
| chanValid | output | 1 | A channel was selected |
| chanSel | output | 1 | 0 = channel A, 1 = channel B |
| localAddr | output | ADDR_W | Address within the selected channel |
| outOfRange | output | 1 | Address beyond installed memory |

## Verification
The bench builds the block with ADDR_W=12, CAP_W=4 and UNIT_BITS=8, so that one capacity unit holds four 64-byte lines. Under these settings the whole 4096-byte address space can be swept exhaustively for several capacity pairs in each mode. The swept cases include the zone boundary, the top of each channel and the first out-of-range byte. REG_OUT=1 puts the one-cycle latency and the reset clearing within reach.

// File: rtl/addrmap_pkg.sv
package addrmap_pkg;

  typedef enum logic [1:0] {
    MODE_SINGLE = 2'd0,
    MODE_FLEX   = 2'd1,
    MODE_ASYM   = 2'd2,
    MODE_RSVD   = 2'd3
  } mapMode_e;

  typedef enum logic [1:0] {
    OFS_NONE  = 2'd0,
    OFS_CAPA  = 2'd1,
    OFS_SMALL = 2'd2
  } offsetSel_e;

  // strobes from control to datapath
  typedef struct packed {
    logic       hit;      // a channel is selected
    logic       chan;     // 0 = A, 1 = B
    logic       squeeze;  // drop the channel-select bit
    offsetSel_e ofs;      // base subtracted for linear regions
  } mapStrobe_t;

endpackage

// File: rtl/flex_map_ctrl.sv
module flex_map_ctrl
  import addrmap_pkg::*;
#(
  parameter int ADDR_W    = 36,
  parameter int CAP_W     = 10,
  parameter int UNIT_BITS = 26,
  parameter int LINE_BITS = 6
) (
  input  logic [ADDR_W-1:0] sysAddr,
  input  logic [CAP_W-1:0]  capUnitsA,
  input  logic [CAP_W-1:0]  capUnitsB,
  input  logic [1:0]        mapMode,
  output mapStrobe_t        strobe
);
  localparam int SUM_W = ADDR_W + 2;

  logic [SUM_W-1:0] bytesA, bytesB, bytesSmall, zoneEnd, bytesTotal, addrExt;
  mapMode_e modeSel;

  assign bytesA     = SUM_W'(capUnitsA) << UNIT_BITS;
  assign bytesB     = SUM_W'(capUnitsB) << UNIT_BITS;
  assign bytesSmall = (capUnitsA < capUnitsB) ? bytesA : bytesB;
  assign zoneEnd    = bytesSmall << 1;
  assign bytesTotal = bytesA + bytesB;
  assign addrExt    = SUM_W'(sysAddr);
  assign modeSel    = mapMode_e'(mapMode);

  always_comb begin
    strobe = '0;
    case (modeSel)
      MODE_SINGLE: begin
        if (capUnitsA != '0) begin
          if (addrExt < bytesA) strobe.hit = 1'b1;
        end else if (addrExt < bytesB) begin
          strobe.hit  = 1'b1;
          strobe.chan = 1'b1;
        end
      end
      MODE_FLEX: begin
        if (addrExt < bytesTotal) begin
          strobe.hit = 1'b1;
          if (addrExt < zoneEnd) begin
            strobe.chan    = sysAddr[LINE_BITS];
            strobe.squeeze = 1'b1;
          end else begin
            strobe.chan = (capUnitsB > capUnitsA);
            strobe.ofs  = OFS_SMALL;
          end
        end
      end
      MODE_ASYM: begin
        if (addrExt < bytesTotal) begin
          strobe.hit = 1'b1;
          if (addrExt >= bytesA) begin
            strobe.chan = 1'b1;
            strobe.ofs  = OFS_CAPA;
          end
        end
      end
      default: strobe = '0;
    endcase
  end

endmodule

// File: rtl/flex_map_dp.sv
module flex_map_dp
  import addrmap_pkg::*;
#(
  parameter int ADDR_W    = 36,
  parameter int CAP_W     = 10,
  parameter int UNIT_BITS = 26,
  parameter int LINE_BITS = 6
) (
  input  logic [ADDR_W-1:0] sysAddr,
  input  logic [CAP_W-1:0]  capUnitsA,
  input  logic [CAP_W-1:0]  capUnitsB,
  input  mapStrobe_t        strobe,
  output logic              chanValid,
  output logic              chanSel,
  output logic [ADDR_W-1:0] localAddr,
  output logic              outOfRange
);
  // Offsets only matter when they do not exceed the address, so the
  // truncation to ADDR_W loses nothing that is used.
  logic [ADDR_W-1:0] baseA, baseSmall, offset, linearAddr;
  logic [ADDR_W-2:0] squeezed;

  assign baseA     = ADDR_W'(capUnitsA) << UNIT_BITS;
  assign baseSmall = (capUnitsA < capUnitsB) ? baseA : (ADDR_W'(capUnitsB) << UNIT_BITS);

  always_comb begin
    case (strobe.ofs)
      OFS_CAPA:  offset = baseA;
      OFS_SMALL: offset = baseSmall;
      default:   offset = '0;
    endcase
  end

  assign linearAddr = sysAddr - offset;
  assign squeezed   = {sysAddr[ADDR_W-1:LINE_BITS+1], sysAddr[LINE_BITS-1:0]};

  always_comb begin
    chanValid  = strobe.hit;
    outOfRange = !strobe.hit;
    chanSel    = strobe.hit & strobe.chan;
    if (!strobe.hit)         localAddr = '0;
    else if (strobe.squeeze) localAddr = {1'b0, squeezed};
    else                     localAddr = linearAddr;
  end

endmodule

// File: rtl/flex_chan_mapper.sv
module flex_chan_mapper
  import addrmap_pkg::*;
#(
  parameter int ADDR_W    = 36,
  parameter int CAP_W     = 10,
  parameter int UNIT_BITS = 26,
  parameter int LINE_BITS = 6,
  parameter bit REG_OUT   = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] sysAddr,
  input  logic [CAP_W-1:0]  capUnitsA,
  input  logic [CAP_W-1:0]  capUnitsB,
  input  logic [1:0]        mapMode,
  output logic              chanValid,
  output logic              chanSel,
  output logic [ADDR_W-1:0] localAddr,
  output logic              outOfRange
);
  mapStrobe_t        strobe;
  logic              nxtValid, nxtSel, nxtOor;
  logic [ADDR_W-1:0] nxtLocal;

  flex_map_ctrl #(.ADDR_W(ADDR_W), .CAP_W(CAP_W), .UNIT_BITS(UNIT_BITS),
                  .LINE_BITS(LINE_BITS)) u_ctrl (
    .sysAddr(sysAddr), .capUnitsA(capUnitsA), .capUnitsB(capUnitsB),
    .mapMode(mapMode), .strobe(strobe));

  flex_map_dp #(.ADDR_W(ADDR_W), .CAP_W(CAP_W), .UNIT_BITS(UNIT_BITS),
                .LINE_BITS(LINE_BITS)) u_dp (
    .sysAddr(sysAddr), .capUnitsA(capUnitsA), .capUnitsB(capUnitsB),
    .strobe(strobe), .chanValid(nxtValid), .chanSel(nxtSel),
    .localAddr(nxtLocal), .outOfRange(nxtOor));

  generate
    if (REG_OUT) begin : g_reg
      always_ff @(posedge clk) begin
        if (rst) begin
          chanValid  <= 1'b0;
          chanSel    <= 1'b0;
          localAddr  <= '0;
          outOfRange <= 1'b0;
        end else begin
          chanValid  <= nxtValid;
          chanSel    <= nxtSel;
          localAddr  <= nxtLocal;
          outOfRange <= nxtOor;
        end
      end
    end else begin : g_comb
      assign chanValid  = nxtValid;
      assign chanSel    = nxtSel;
      assign localAddr  = nxtLocal;
      assign outOfRange = nxtOor;
    end
  endgenerate

endmodule

// File: rtl/flex_chan_mapper_chk.sv
module flex_chan_mapper_chk #(
  parameter int ADDR_W    = 36,
  parameter int CAP_W     = 10,
  parameter int UNIT_BITS = 26,
  parameter int LINE_BITS = 6,
  parameter bit REG_OUT   = 1'b1
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] sysAddr,
  input logic [CAP_W-1:0]  capUnitsA,
  input logic [CAP_W-1:0]  capUnitsB,
  input logic [1:0]        mapMode,
  input logic              chanValid,
  input logic              chanSel,
  input logic [ADDR_W-1:0] localAddr,
  input logic              outOfRange
);
  localparam int SUM_W = ADDR_W + 2;

  logic [ADDR_W-1:0] dAddr;
  logic [CAP_W-1:0]  dCapA, dCapB;
  logic [1:0]        dMode;
  logic [SUM_W-1:0]  bA, bB, bSmall, dAddrExt;

  generate
    if (REG_OUT) begin : g_dly
      always_ff @(posedge clk) begin
        if (rst) begin
          dAddr <= '0; dCapA <= '0; dCapB <= '0; dMode <= '0;
        end else begin
          dAddr <= sysAddr; dCapA <= capUnitsA; dCapB <= capUnitsB; dMode <= mapMode;
        end
      end
    end else begin : g_now
      assign dAddr = sysAddr;
      assign dCapA = capUnitsA;
      assign dCapB = capUnitsB;
      assign dMode = mapMode;
    end
  endgenerate

  assign bA       = SUM_W'(dCapA) << UNIT_BITS;
  assign bB       = SUM_W'(dCapB) << UNIT_BITS;
  assign bSmall   = (bA < bB) ? bA : bB;
  assign dAddrExt = SUM_W'(dAddr);

  // R6
  oor_clears_chk: assert property (@(posedge clk) disable iff (rst)
    outOfRange |-> (!chanValid && !chanSel && localAddr == '0));

  // R7
  local_in_chan_chk: assert property (@(posedge clk) disable iff (rst)
    chanValid |-> (SUM_W'(localAddr) < (chanSel ? bB : bA)));

  // R1
  interleave_line_chk: assert property (@(posedge clk) disable iff (rst)
    (chanValid && dMode == 2'd1 && dAddrExt < (bSmall << 1)) |-> (chanSel == dAddr[LINE_BITS]));

  // R4
  asym_fill_chk: assert property (@(posedge clk) disable iff (rst)
    (chanValid && dMode == 2'd2) |-> (chanSel == (dAddrExt >= bA)));

  // R5
  single_identity_chk: assert property (@(posedge clk) disable iff (rst)
    (chanValid && dMode == 2'd0) |-> (localAddr == dAddr));

endmodule

bind flex_chan_mapper flex_chan_mapper_chk #(
  .ADDR_W(ADDR_W), .CAP_W(CAP_W), .UNIT_BITS(UNIT_BITS),
  .LINE_BITS(LINE_BITS), .REG_OUT(REG_OUT)
) u_chk (
  .clk(clk), .rst(rst), .sysAddr(sysAddr), .capUnitsA(capUnitsA),
  .capUnitsB(capUnitsB), .mapMode(mapMode), .chanValid(chanValid),
  .chanSel(chanSel), .localAddr(localAddr), .outOfRange(outOfRange));

// File: tb/sim_flex_chan_mapper.sv
module sim_flex_chan_mapper;
  localparam int ADDR_W = 12, CAP_W = 4, UNIT_BITS = 8, LINE_BITS = 6;

  logic clk = 1'b0, rst = 1'b1;
  logic [ADDR_W-1:0] sysAddr = '0;
  logic [CAP_W-1:0]  capUnitsA = '0, capUnitsB = '0;
  logic [1:0]        mapMode = '0;
  logic              chanValid, chanSel, outOfRange;
  logic [ADDR_W-1:0] localAddr;
  int checks = 0, errors = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  flex_chan_mapper #(.ADDR_W(ADDR_W), .CAP_W(CAP_W), .UNIT_BITS(UNIT_BITS),
                     .LINE_BITS(LINE_BITS), .REG_OUT(1'b1)) u0 (
    .clk(clk), .rst(rst), .sysAddr(sysAddr), .capUnitsA(capUnitsA),
    .capUnitsB(capUnitsB), .mapMode(mapMode), .chanValid(chanValid),
    .chanSel(chanSel), .localAddr(localAddr), .outOfRange(outOfRange));

  task automatic cmp(string tag, bit eV, bit eC, int eL, bit eO);
    checks++;
    if (chanValid !== eV || chanSel !== eC || int'(localAddr) !== eL || outOfRange !== eO) begin
      errors++;
      $display("FAIL %s: got v=%0b ch=%0b loc=%0d oor=%0b exp v=%0b ch=%0b loc=%0d oor=%0b",
               tag, chanValid, chanSel, localAddr, outOfRange, eV, eC, eL, eO);
    end
  endtask

  // drive at a falling edge, result is registered at the next rising edge
  task automatic expect_map(string tag, int md, int ca, int cb, int a,
                            bit eV, bit eC, int eL, bit eO);
    @(negedge clk);
    mapMode = md[1:0]; capUnitsA = ca[CAP_W-1:0]; capUnitsB = cb[CAP_W-1:0];
    sysAddr = a[ADDR_W-1:0];
    @(negedge clk);
    cmp(tag, eV, eC, eL, eO);
  endtask

  // model built from the requirement text
  task automatic model(int md, int ca, int cb, int a,
                       output bit v, output bit c, output int l, output bit o);
    int bA = ca * 256, bB = cb * 256, sm;
    v = 0; c = 0; l = 0; o = 1;
    sm = (bA < bB) ? bA : bB;
    if (md == 0) begin
      if (ca != 0) begin if (a < bA) begin v = 1; l = a; end end
      else if (a < bB) begin v = 1; c = 1; l = a; end
    end else if (md == 1 && a < bA + bB) begin
      v = 1;
      if (a < 2 * sm) begin c = (a / 64) % 2; l = (a / 128) * 64 + a % 64; end
      else begin c = (cb > ca); l = a - sm; end
    end else if (md == 2 && a < bA + bB) begin
      v = 1;
      if (a < bA) l = a; else begin c = 1; l = a - bA; end
    end
    if (v) o = 0;
  endtask

  task automatic sweep(string tag, int md, int ca, int cb);
    bit v, c, o; int l;
    for (int a = 0; a < 4096; a++) begin
      model(md, ca, cb, a, v, c, l, o);
      expect_map(tag, md, ca, cb, a, v, c, l, o);
    end
  endtask

  task automatic t_reset();
    @(negedge clk);
    cmp("R8 reset clears outputs", 0, 0, 0, 0);
  endtask

  task automatic t_flex_equal();
    expect_map("R3 line0 ch A", 1, 4, 4, 0, 1, 0, 0, 0);
    expect_map("R3 line1 ch B", 1, 4, 4, 64, 1, 1, 0, 0);
    expect_map("R3 line2 ch A", 1, 4, 4, 128 + 5, 1, 0, 69, 0);
    expect_map("R3 top byte", 1, 4, 4, 2047, 1, 1, 1023, 0);
    expect_map("R6 first byte past total", 1, 4, 4, 2048, 0, 0, 0, 1);
  endtask

  task automatic t_flex_uneven();
    expect_map("R1 last interleaved", 1, 2, 5, 1023, 1, 1, 511, 0);
    expect_map("R2 first linear B", 1, 2, 5, 1024, 1, 1, 512, 0);
    expect_map("R2 top of B", 1, 2, 5, 1791, 1, 1, 1279, 0);
    expect_map("R6 past flex total", 1, 2, 5, 1792, 0, 0, 0, 1);
    expect_map("R2 larger is A", 1, 6, 1, 600, 1, 0, 344, 0);
    expect_map("R2 empty B all to A", 1, 3, 0, 100, 1, 0, 100, 0);
  endtask

  task automatic t_asym();
    expect_map("R4 top of A", 2, 3, 2, 767, 1, 0, 767, 0);
    expect_map("R4 bottom of B", 2, 3, 2, 768, 1, 1, 0, 0);
    expect_map("R4 top of B", 2, 3, 2, 1279, 1, 1, 511, 0);
    expect_map("R6 past asym total", 2, 3, 2, 1280, 0, 0, 0, 1);
  endtask

  task automatic t_single();
    expect_map("R5 only B populated", 0, 0, 3, 700, 1, 1, 700, 0);
    expect_map("R6 past B alone", 0, 0, 3, 768, 0, 0, 0, 1);
    expect_map("R5 A wins when both set", 0, 2, 5, 511, 1, 0, 511, 0);
    expect_map("R5 B ignored in single", 0, 2, 5, 512, 0, 0, 0, 1);
    expect_map("R6 reserved mode", 3, 4, 4, 10, 0, 0, 0, 1);
  endtask

  task automatic t_latency();
    expect_map("R8 setup", 2, 3, 2, 800, 1, 1, 32, 0);
    sysAddr = 12'd5;
    #1 cmp("R8 holds before edge", 1, 1, 32, 0);
    @(negedge clk);
    cmp("R8 updates after edge", 1, 0, 5, 0);
  endtask

  task automatic t_sweeps();
    sweep("R1 R2 R7 flex 3/5", 1, 3, 5);
    sweep("R1 R2 R7 flex 7/2", 1, 7, 2);
    sweep("R4 R7 asym 5/4", 2, 5, 4);
    sweep("R5 R7 single B", 0, 0, 6);
  endtask

  initial begin
    repeat (2) @(posedge clk);
    t_reset();
    @(negedge clk) rst = 1'b0;
    t_flex_equal();
    t_flex_uneven();
    t_asym();
    t_single();
    t_latency();
    t_sweeps();
    if (!finished) begin
      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #(20 * 190000);
    if (!finished) begin
      finished = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule